// File: doc/BRIEF.md
# Saturating Rounding Variable Shifter Lane

This block shifts one integer element by a signed, per-operation shift count and registers the result. A positive count shifts left. A negative count shifts right, and the right shift can round to nearest with ties going upward. A left shift that loses significant bits can clamp to the limit of the element type when saturation is enabled. When saturation is disabled, such a shift wraps to the low bits instead. The element can be 8, 16, 32 or 64 bits wide. It can be read as signed or unsigned. A third mode takes a signed source and produces an unsigned result.

One operation is accepted per clock when `in_valid` is high. The result is registered and appears, together with `out_valid`, after the next rising edge. Every operation that clamps sets a sticky saturation flag. The flag stays set until the synchronous `sat_clr` input clears it. A vector unit places one of these lanes per element. Packing the lanes, predication and decode belong to the surrounding logic.

Top module: `sat_shift_lane`

## Requirements
- R1: `size` selects the element width: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits. Only the low element bits of `src` are used, and `result` bits above the element are 0. `mode` 0 is signed, 1 is unsigned, 2 is signed source to unsigned result, and 3 behaves as 1. `shift_cnt` is an 8-bit two's-complement count, and a count of 0 returns the element unchanged.
- R2: Reset sets `out_valid`, `result` and `sat_flag` to 0. An operation sampled with `in_valid` high at a rising edge drives `result` and `out_valid` = 1 after that edge. While `in_valid` is low, `result` holds its value and `out_valid` is 0.
- R3: In signed mode, a count at or below minus the width returns the sign fill of the source (all ones if negative, else 0) without rounding, and returns 0 with rounding.
- R4: For a negative count -n above the zero limits, the result is the source shifted right by n: arithmetically in signed mode, logically otherwise. With rounding on, the last bit shifted out is added, so halves round up.
- R5: In the unsigned modes, the result is 0 for a count at or below -(width+1) with rounding, or at or below -width without rounding. With rounding, a count of exactly -width returns the source's top bit.
- R6: For a count from 0 to width-1, a left shift that keeps the source value exact is returned as is. Otherwise the result clamps if `sat_en` is 1, and otherwise returns the low width bits of the shifted value.
- R7: For a count of width or more, the result is 0 if the source is 0 or `sat_en` is 0. Otherwise it clamps.
- R8: A signed clamp gives the most positive value for a non-negative source and the most negative value for a negative source. An unsigned clamp gives all ones in the element width.
- R9: In mode 2 with `sat_en` = 1, a negative source gives 0 and counts as a clamp. With `sat_en` = 0, mode 2 behaves as unsigned on the raw bits.
- R10: `sat_flag` is set after an edge where a valid operation clamps, which can only happen with `sat_en` = 1. `sat_clr` clears it, and no operation clears it. When a clear and a clamp fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| src | input | 64 | Source element, in the low bits |
| shift_cnt | input | 8 | Signed shift count |
| mode | input | 2 | Interpretation: signed, unsigned, signed-to-unsigned |
| size | input | 2 | Element width select |
| round_en | input | 1 | Round right shifts |
| sat_en | input | 1 | Clamp on overflow |
| sat_clr | input | 1 | Synchronous clear of the sticky flag |
| out_valid | output | 1 | Result register holds a new result |
| result | output | 64 | Shifted element, zero above the element width |
| sat_flag | output | 1 | Sticky saturation status |

## Verification
A flag clear and a clamping operation can fall in the same cycle. The table walk provokes this on every vector, because it issues each one with `sat_clr` high. After each vector, the flag must then equal exactly that vector's own clamp outcome. Directed steps then set the flag and issue clear-plus-clamp and clear-plus-clean operations back to back. They check that the set wins and that a clean operation with the clear leaves the flag at 0.

// File: rtl/shl_pkg.sv
`timescale 1ns/100ps
package shl_pkg;
    localparam int MIN_W     = 8;
    localparam int NUM_SIZES = 4;
    localparam int MAX_W     = MIN_W << (NUM_SIZES - 1);
    localparam int SIZE_W    = $clog2(NUM_SIZES);

    typedef enum logic [1:0] {
        MODE_SIGNED   = 2'd0,
        MODE_UNSIGNED = 2'd1,
        MODE_S2U      = 2'd2,
        MODE_ALT      = 2'd3
    } shl_mode_e;
endpackage

// File: rtl/shl_lane_core.sv
`timescale 1ns/100ps
module shl_lane_core
    import shl_pkg::*;
#(
    parameter int W     = 8,
    parameter int CNT_W = 8
) (
    input  logic [W-1:0]     src,
    input  logic [CNT_W-1:0] cnt,
    input  shl_mode_e        mode,
    input  logic             round_en,
    input  logic             sat_en,
    output logic [W-1:0]     res,
    output logic             hit
);
    localparam int EW = CNT_W + 2;
    localparam logic signed [EW-1:0] POS_W  = EW'(W);
    localparam logic signed [EW-1:0] NEG_W  = -POS_W;
    localparam logic signed [EW-1:0] NEG_W1 = NEG_W - EW'(1);

    logic signed [EW-1:0] c;
    logic [EW-1:0] mag;
    logic [EW-1:0] rmag;
    logic [EW-1:0] lamt;
    logic [W-1:0]  s_tr, s_t, s_rnd;
    logic [W-1:0]  u_tr, u_t, u_rnd;
    logic [W-1:0]  lv, s_back, u_back;
    logic [W-1:0]  s_clamp, u_clamp;
    logic          fits_s, fits_u;
    logic          is_neg_cnt;

    // count widened with sign, magnitude for right shifts, raw for left
    assign c          = {{2{cnt[CNT_W-1]}}, cnt};
    assign mag        = -c;
    assign rmag       = mag - EW'(1);
    assign lamt       = c;
    assign is_neg_cnt = c[EW-1];

    // right-shift candidates
    assign s_tr  = $signed(src) >>> mag;
    assign s_t   = $signed(src) >>> rmag;
    assign s_rnd = W'($signed(s_t) >>> 1) + W'(s_t[0]);
    assign u_tr  = src >> mag;
    assign u_t   = src >> rmag;
    assign u_rnd = (u_t >> 1) + W'(u_t[0]);

    // left-shift candidate and exactness checks
    assign lv     = src << lamt;
    assign s_back = $signed(lv) >>> lamt;
    assign u_back = lv >> lamt;
    assign fits_s = (s_back == src);
    assign fits_u = (u_back == src);

    assign s_clamp = src[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    assign u_clamp = {W{1'b1}};

    always_comb begin
        res = '0;
        hit = 1'b0;
        if (mode == MODE_S2U && sat_en && src[W-1]) begin
            res = '0;
            hit = 1'b1;
        end else if (mode == MODE_SIGNED) begin
            if (c <= NEG_W) begin
                res = round_en ? '0 : {W{src[W-1]}};
            end else if (is_neg_cnt) begin
                res = round_en ? s_rnd : s_tr;
            end else if (c < POS_W) begin
                if (fits_s || !sat_en) begin
                    res = lv;
                end else begin
                    res = s_clamp;
                    hit = 1'b1;
                end
            end else if (!sat_en || src == '0) begin
                res = '0;
            end else begin
                res = s_clamp;
                hit = 1'b1;
            end
        end else begin
            if (round_en ? (c <= NEG_W1) : (c <= NEG_W)) begin
                res = '0;
            end else if (is_neg_cnt) begin
                res = round_en ? u_rnd : u_tr;
            end else if (c < POS_W) begin
                if (fits_u || !sat_en) begin
                    res = lv;
                end else begin
                    res = u_clamp;
                    hit = 1'b1;
                end
            end else if (!sat_en || src == '0) begin
                res = '0;
            end else begin
                res = u_clamp;
                hit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/shl_sticky.sv
`timescale 1ns/100ps
module shl_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic set,
    output logic flag
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = (flag_q & ~clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;

    // R10: only a clear may drop the flag
    a_r10_keep_set: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr) |=> flag_q);
    // R10: a clamp wins over a simultaneous clear
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag_q);
endmodule

// File: rtl/sat_shift_lane.sv
`timescale 1ns/100ps
module sat_shift_lane
    import shl_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [MAX_W-1:0]  src,
    input  logic [CNT_W-1:0]  shift_cnt,
    input  logic [1:0]        mode,
    input  logic [SIZE_W-1:0] size,
    input  logic              round_en,
    input  logic              sat_en,
    input  logic              sat_clr,
    output logic              out_valid,
    output logic [MAX_W-1:0]  result,
    output logic              sat_flag
);
    typedef struct packed {
        logic             vld;
        logic [MAX_W-1:0] res;
    } stage_t;

    stage_t                 stage_d, stage_q;
    shl_mode_e              mode_e;
    logic [MAX_W-1:0]       lane_res [NUM_SIZES];
    logic [NUM_SIZES-1:0]   lane_hit;
    logic [NUM_SIZES-1:0]   lane_msb;
    logic                   hit_now;
    logic                   src_msb;

    assign mode_e = shl_mode_e'(mode);

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_lane
        localparam int LW = MIN_W << g;
        logic [LW-1:0] lane_r;
        shl_lane_core #(.W(LW), .CNT_W(CNT_W)) u_core (
            .src      (src[LW-1:0]),
            .cnt      (shift_cnt),
            .mode     (mode_e),
            .round_en (round_en),
            .sat_en   (sat_en),
            .res      (lane_r),
            .hit      (lane_hit[g])
        );
        assign lane_res[g] = MAX_W'(lane_r);
        assign lane_msb[g] = src[LW-1];
    end

    assign src_msb = lane_msb[size];

    always_comb begin
        stage_d     = stage_q;
        stage_d.vld = in_valid;
        if (in_valid) stage_d.res = lane_res[size];
        hit_now     = in_valid & lane_hit[size];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    shl_sticky u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sat_clr),
        .set   (hit_now),
        .flag  (sat_flag)
    );

    assign out_valid = stage_q.vld;
    assign result    = stage_q.res;

    // R2: valid tracks the accepted operation one edge later
    a_r2_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2: idle cycles leave the result untouched
    a_r2_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result)));
    // R7: a zero source shifts to zero in every mode and direction
    a_r7_zero_source: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && src == '0) |=> (result == '0));
    // R9: negative source into unsigned result clamps to zero
    a_r9_neg_source: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'd2 && sat_en && src_msb) |=> (result == '0 && sat_flag));
    // R10: without saturation and without a clear the flag is quiet
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!sat_en && !sat_clr) |=> $stable(sat_flag));
endmodule

// File: tb/sim_sat_shift_lane.sv
`timescale 1ns/100ps
module sim_sat_shift_lane;
    typedef struct packed {
        logic [3:0]  req;
        logic [1:0]  mode;
        logic [1:0]  size;
        logic        rnd;
        logic        sat;
        logic [7:0]  sh;
        logic [63:0] src;
        logic [63:0] exp;
        logic        esat;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t TAB [NV] = '{
        '{4'd3,  2'd0, 2'd0, 1'b0, 1'b0, 8'hF8, 64'h80, 64'hFF, 1'b0},                 // R3 sign fill
        '{4'd3,  2'd0, 2'd0, 1'b1, 1'b0, 8'hF8, 64'h80, 64'h00, 1'b0},                 // R3 rounded -> 0
        '{4'd4,  2'd0, 2'd0, 1'b0, 1'b0, 8'hFD, 64'h90, 64'hF2, 1'b0},                 // R4 arith shift
        '{4'd4,  2'd0, 2'd0, 1'b1, 1'b0, 8'hFD, 64'h94, 64'hF3, 1'b0},                 // R4 -13.5 -> -13
        '{4'd5,  2'd1, 2'd0, 1'b1, 1'b0, 8'hF8, 64'h80, 64'h01, 1'b0},                 // R5 -W rounded
        '{4'd5,  2'd1, 2'd0, 1'b1, 1'b0, 8'hF7, 64'hFF, 64'h00, 1'b0},                 // R5 -(W+1)
        '{4'd5,  2'd1, 2'd0, 1'b0, 1'b0, 8'hF8, 64'hFF, 64'h00, 1'b0},                 // R5 -W plain
        '{4'd4,  2'd1, 2'd1, 1'b1, 1'b0, 8'hFC, 64'h18, 64'h02, 1'b0},                 // R4 1.5 -> 2
        '{4'd6,  2'd0, 2'd1, 1'b0, 1'b1, 8'h04, 64'h07FF, 64'h7FF0, 1'b0},             // R6 fits
        '{4'd6,  2'd0, 2'd1, 1'b0, 1'b1, 8'h05, 64'h07FF, 64'h7FFF, 1'b1},             // R6 clamp
        '{4'd6,  2'd0, 2'd1, 1'b0, 1'b0, 8'h05, 64'h07FF, 64'hFFE0, 1'b0},             // R6 wrap
        '{4'd8,  2'd0, 2'd2, 1'b0, 1'b1, 8'h01, 64'h80000000, 64'h80000000, 1'b1},     // R8 signed min
        '{4'd8,  2'd1, 2'd2, 1'b0, 1'b1, 8'h01, 64'h80000000, 64'hFFFFFFFF, 1'b1},     // R8 unsigned max
        '{4'd6,  2'd1, 2'd2, 1'b0, 1'b0, 8'h01, 64'h80000001, 64'h00000002, 1'b0},     // R6 unsigned wrap
        '{4'd7,  2'd0, 2'd3, 1'b0, 1'b1, 8'd64, 64'h0, 64'h0, 1'b0},                   // R7 zero source
        '{4'd7,  2'd0, 2'd3, 1'b0, 1'b1, 8'd70, 64'hFFFFFFFFFFFFFFFF, 64'h8000000000000000, 1'b1}, // R7 clamp
        '{4'd7,  2'd0, 2'd3, 1'b0, 1'b0, 8'd100, 64'h5, 64'h0, 1'b0},                  // R7 no sat
        '{4'd7,  2'd1, 2'd0, 1'b0, 1'b1, 8'd8, 64'h01, 64'hFF, 1'b1},                  // R7 unsigned clamp
        '{4'd9,  2'd2, 2'd0, 1'b0, 1'b1, 8'h00, 64'h80, 64'h00, 1'b1},                 // R9 negative
        '{4'd9,  2'd2, 2'd0, 1'b0, 1'b0, 8'hFF, 64'h80, 64'h40, 1'b0},                 // R9 raw bits
        '{4'd9,  2'd2, 2'd1, 1'b0, 1'b1, 8'h02, 64'h1234, 64'h48D0, 1'b0},             // R9 positive
        '{4'd4,  2'd0, 2'd3, 1'b1, 1'b0, 8'hFF, 64'h3, 64'h2, 1'b0},                   // R4 64-bit round
        '{4'd5,  2'd1, 2'd3, 1'b1, 1'b0, 8'hC0, 64'h8000000000000000, 64'h1, 1'b0},    // R5 64-bit -W
        '{4'd3,  2'd0, 2'd3, 1'b0, 1'b0, 8'h80, 64'h8000000000000001, 64'hFFFFFFFFFFFFFFFF, 1'b0}, // R3 -128
        '{4'd1,  2'd3, 2'd0, 1'b0, 1'b1, 8'h01, 64'h80, 64'hFF, 1'b1},                 // R1 mode 3 unsigned
        '{4'd1,  2'd0, 2'd0, 1'b0, 1'b0, 8'h00, 64'h5A, 64'h5A, 1'b0},                 // R1 zero count
        '{4'd6,  2'd0, 2'd0, 1'b1, 1'b1, 8'h01, 64'h3F, 64'h7E, 1'b0},                 // R6 rounding ignored left
        '{4'd1,  2'd0, 2'd0, 1'b0, 1'b0, 8'h00, 64'hABCDEF1234567890, 64'h90, 1'b0}    // R1 upper bits
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [63:0] src;
    logic [7:0]  shift_cnt;
    logic [1:0]  mode;
    logic [1:0]  size;
    logic        round_en;
    logic        sat_en;
    logic        sat_clr;
    logic        out_valid;
    logic [63:0] result;
    logic        sat_flag;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    sat_shift_lane u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src),
        .shift_cnt(shift_cnt), .mode(mode), .size(size), .round_en(round_en),
        .sat_en(sat_en), .sat_clr(sat_clr), .out_valid(out_valid),
        .result(result), .sat_flag(sat_flag)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // drive one operation at a falling edge, sample at the next falling edge
    task automatic op(input logic [1:0] m, input logic [1:0] s, input logic r,
                      input logic sa, input logic [7:0] sh, input logic [63:0] x,
                      input logic clr);
        @(negedge clk);
        in_valid = 1'b1; mode = m; size = s; round_en = r; sat_en = sa;
        shift_cnt = sh; src = x; sat_clr = clr;
        @(negedge clk);
        in_valid = 1'b0; sat_clr = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
        finish_run();
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; src = '0; shift_cnt = '0; mode = '0;
        size = '0; round_en = 1'b0; sat_en = 1'b0; sat_clr = 1'b0;
        repeat (3) @(negedge clk);
        // R2 reset state
        chk("R2 reset out_valid", 64'(out_valid), 64'h0);
        chk("R2 reset result", result, 64'h0);
        chk("R10 reset flag", 64'(sat_flag), 64'h0);
        rst_n = 1'b1;

        // table walk; each vector carries a clear so the flag shows its own clamp
        for (int k = 0; k < NV; k++) begin
            op(TAB[k].mode, TAB[k].size, TAB[k].rnd, TAB[k].sat, TAB[k].sh, TAB[k].src, 1'b1);
            chk($sformatf("R%0d vec%0d result", TAB[k].req, k), result, TAB[k].exp);
            chk($sformatf("R10 vec%0d flag (R%0d)", k, TAB[k].req), 64'(sat_flag), 64'(TAB[k].esat));
            chk($sformatf("R2 vec%0d out_valid", k), 64'(out_valid), 64'h1);
        end

        // R2: hold while idle, new inputs ignored
        op(2'd0, 2'd0, 1'b0, 1'b0, 8'h01, 64'h12, 1'b1);
        chk("R2 result 0x24", result, 64'h24);
        src = 64'h77; shift_cnt = 8'h03; sat_en = 1'b1;
        @(negedge clk);
        chk("R2 idle hold result", result, 64'h24);
        chk("R2 idle out_valid", 64'(out_valid), 64'h0);

        // R10: sticky behaviour
        op(2'd1, 2'd0, 1'b0, 1'b1, 8'd8, 64'h01, 1'b0);
        chk("R10 set by clamp", 64'(sat_flag), 64'h1);
        op(2'd1, 2'd0, 1'b0, 1'b1, 8'd0, 64'h01, 1'b0);
        chk("R10 clean op keeps flag", 64'(sat_flag), 64'h1);
        chk("R1 clean op result", result, 64'h01);
        op(2'd0, 2'd1, 1'b0, 1'b0, 8'd5, 64'h07FF, 1'b0);
        chk("R10 unsat overflow keeps flag", 64'(sat_flag), 64'h1);
        @(negedge clk); sat_clr = 1'b1;
        @(negedge clk); sat_clr = 1'b0;
        chk("R10 clear alone", 64'(sat_flag), 64'h0);
        op(2'd0, 2'd1, 1'b0, 1'b0, 8'd5, 64'h07FF, 1'b0);
        chk("R10 no set without sat_en", 64'(sat_flag), 64'h0);
        // clamping inputs present but not valid: ignored
        mode = 2'd1; size = 2'd0; sat_en = 1'b1; shift_cnt = 8'd8; src = 64'h01;
        @(negedge clk); @(negedge clk);
        chk("R10 invalid op ignored", 64'(sat_flag), 64'h0);
        // clear and clamp in one cycle: set wins
        op(2'd1, 2'd0, 1'b0, 1'b1, 8'd8, 64'h01, 1'b0);
        op(2'd0, 2'd2, 1'b0, 1'b1, 8'd1, 64'h80000000, 1'b1);
        chk("R10 clear+clamp sets", 64'(sat_flag), 64'h1);
        chk("R8 clear+clamp result", result, 64'h80000000);
        op(2'd0, 2'd0, 1'b0, 1'b1, 8'd1, 64'h10, 1'b1);
        chk("R10 clear+clean clears", 64'(sat_flag), 64'h0);
        chk("R6 clear+clean result", result, 64'h20);

        finish_run();
    end
endmodule